// File: doc/BRIEF.md
# Masked Interrupt Status Latch

This block keeps an 8-bit interrupt status byte next to an 8-bit enable mask and pulls a shared, active-low interrupt line whenever an enabled status bit is pending. Two sources set status bits. The first is a free-running tick that fires once every `TICK_CYCLES` clock cycles. The second is a completed peripheral-bus autopoll result, which brings a short reply payload of up to `MAX_REPLY` bytes. The block holds that payload until the host collects it.

The host side reads and clears the status through an acknowledge request. If a bus reply is waiting, the acknowledge returns a header byte followed by the payload, and it clears only the two bus-related bits. Otherwise it returns the whole status byte and clears every bit. The mask is loaded through a plain write strobe. The bus itself and the serial transport that carries these requests are outside this block.

Top module: `intr_status_latch`

## Requirements
- R1: `irqN` is low exactly when (status AND mask) is nonzero. It follows every registered change of status or mask in that same cycle.
- R2: After reset the status is 0x00, the mask enables only the bus bit (bit 4) and the tick bit (bit 3), `irqN` is high and `rspValid` is low.
- R3: The tick bit (bit 3) is set on the `TICK_CYCLES`-th rising edge after reset release and on every `TICK_CYCLES` edges after that. An acknowledge never shifts this schedule.
- R4: A poll result (`pollValid`) is captured only while the bus bit is clear and `pollLen` is nonzero. Capture stores the payload with bytes at index `pollLen` and above zeroed, then sets the bus bit (bit 4) and the autopoll bit (bit 2). Any other poll result changes nothing.
- R5: An acknowledge with `ackArgCnt` = 0 while the bus bit is set produces the following on the next cycle: `rspValid` high, `rspLen` = stored length + 1, `rspData[7:0]` holding only bits 4 and 2 of the status, and the payload in bytes 1 and up (byte i at `rspData[8i+7:8i]`). It then clears bits 4 and 2 and empties the payload, and it leaves every other status bit unchanged.
- R6: An acknowledge with `ackArgCnt` = 0 while the bus bit is clear produces the following on the next cycle: `rspLen` = 1, `rspData[7:0]` = the full status byte and all other bytes zero. It then clears the whole status byte.
- R7: An acknowledge with nonzero `ackArgCnt` produces no response and changes no state.
- R8: When a set event (tick or poll capture) and an acknowledge clear hit the same bit in the same cycle, the bit ends up set.
- R9: `maskWrEn` loads `maskWrData` into the mask at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| maskWrEn | input | 1 | Load strobe for the enable mask |
| maskWrData | input | 8 | New mask value |
| pollValid | input | 1 | Autopoll result present this cycle |
| pollLen | input | LEN_W | Length of the autopoll payload in bytes |
| pollData | input | MAX_REPLY*8 | Autopoll payload, byte i at bits 8i+7:8i |
| ackReq | input | 1 | Interrupt acknowledge request |
| ackArgCnt | input | 8 | Argument count sent with the acknowledge |
| irqN | output | 1 | Interrupt line, active low |
| rspValid | output | 1 | One-cycle pulse marking a response |
| rspLen | output | LEN_W | Number of valid response bytes |
| rspData | output | (MAX_REPLY+1)*8 | Response bytes, byte 0 in bits 7:0 |

## Verification
The bench aims at the collisions that a simple latch tends to get wrong. In one case a tick and an acknowledge fall on the same edge. A design that lets the clear win loses that tick and leaves `irqN` high. In another case a poll capture lands together with a full-status acknowledge. A design that lets the clear win drops the bus reply, so the following acknowledge returns no payload. The bench also acknowledges a bus reply while a tick is pending. A design that clears too widely loses the tick, and one that clears too narrowly keeps reporting the bus. A second poll while a reply is held, a zero-length poll and an acknowledge with arguments are each checked for having no effect. A design that accepts them either overwrites the held payload or answers where it should stay silent. The tick is timed against the reset release and against later edges, which exposes an off-by-one period and any schedule that restarts after an acknowledge.

// File: rtl/intr_latch_pkg.sv
package intr_latch_pkg;

  // Strobes from the control half to the datapath half, valid for one cycle.
  typedef struct packed {
    logic tickSet;   // periodic tick fires on this edge
    logic pollCap;   // capture poll payload, set bus + autopoll bits
    logic ackBus;    // acknowledge returning the bus reply
    logic ackAll;    // acknowledge returning the whole status byte
    logic maskWr;    // load the mask
  } ctrlStrobes_t;

endpackage

// File: rtl/intr_latch_ctrl.sv
module intr_latch_ctrl
  import intr_latch_pkg::*;
#(
  parameter int TICK_CYCLES = 100_000_000,
  parameter int LEN_W       = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             maskWrEn,
  input  logic             pollValid,
  input  logic [LEN_W-1:0] pollLen,
  input  logic             ackReq,
  input  logic [7:0]       ackArgCnt,
  input  logic             busPending,
  output ctrlStrobes_t     strobes
);

  localparam int CNT_W = $clog2(TICK_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TICK_CYCLES - 1);

  logic [CNT_W-1:0] tickCnt;
  logic             tickHit;
  logic             ackOk;

  // Free-running period counter: it wraps on its own, so acks cannot skew it.
  assign tickHit = (tickCnt == CNT_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCnt <= '0;
    end else if (tickHit) begin
      tickCnt <= '0;
    end else begin
      tickCnt <= tickCnt + 1'b1;
    end
  end

  assign ackOk = ackReq && (ackArgCnt == 8'd0);

  always_comb begin
    strobes.tickSet = tickHit;
    strobes.pollCap = pollValid && (pollLen != '0) && !busPending;
    strobes.ackBus  = ackOk && busPending;
    strobes.ackAll  = ackOk && !busPending;
    strobes.maskWr  = maskWrEn;
  end

endmodule

// File: rtl/intr_latch_dp.sv
module intr_latch_dp
  import intr_latch_pkg::*;
#(
  parameter int MAX_REPLY = 8,
  parameter int TICK_BIT  = 3,
  parameter int AUTO_BIT  = 2,
  parameter int BUS_BIT   = 4,
  parameter int LEN_W     = 4,
  parameter int RSP_W     = 72
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrlStrobes_t           strobes,
  input  logic [7:0]             maskWrData,
  input  logic [LEN_W-1:0]       pollLen,
  input  logic [MAX_REPLY*8-1:0] pollData,
  output logic                   busPending,
  output logic                   irqReq,
  output logic                   rspValid,
  output logic [LEN_W-1:0]       rspLen,
  output logic [RSP_W-1:0]       rspData
);

  localparam logic [7:0] TICK_M     = 8'(1 << TICK_BIT);
  localparam logic [7:0] AUTO_M     = 8'(1 << AUTO_BIT);
  localparam logic [7:0] BUS_M      = 8'(1 << BUS_BIT);
  localparam logic [7:0] BUSGRP_M   = BUS_M | AUTO_M;
  localparam logic [7:0] RESET_MASK = BUS_M | TICK_M;
  localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(MAX_REPLY);

  logic [7:0]             status;
  logic [7:0]             statusNext;
  logic [7:0]             maskReg;
  logic [LEN_W-1:0]       replyLen;
  logic [MAX_REPLY*8-1:0] replyBuf;
  logic [LEN_W-1:0]       effLen;
  logic [MAX_REPLY*8-1:0] pollMasked;
  logic [7:0]             setBits;
  logic [7:0]             clrBits;

  // Payload lengths above the buffer size are clamped.
  assign effLen = (pollLen > LEN_MAX) ? LEN_MAX : pollLen;

  // Zero every byte beyond the stated length so the reply is clean.
  for (genvar j = 0; j < MAX_REPLY; j++) begin : g_poll_byte
    assign pollMasked[j*8 +: 8] = (LEN_W'(j) < effLen) ? pollData[j*8 +: 8] : 8'h00;
  end

  // Set terms are OR-ed after the clear, so a set beats a clear.
  always_comb begin
    setBits = 8'h00;
    clrBits = 8'h00;
    if (strobes.tickSet) setBits = setBits | TICK_M;
    if (strobes.pollCap) setBits = setBits | BUSGRP_M;
    if (strobes.ackAll)  clrBits = 8'hFF;
    if (strobes.ackBus)  clrBits = BUSGRP_M;
    statusNext = (status & ~clrBits) | setBits;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      status   <= 8'h00;
      maskReg  <= RESET_MASK;
      replyLen <= '0;
      replyBuf <= '0;
      rspValid <= 1'b0;
      rspLen   <= '0;
      rspData  <= '0;
    end else begin
      status <= statusNext;
      if (strobes.maskWr) begin
        maskReg <= maskWrData;
      end
      if (strobes.pollCap) begin
        replyLen <= effLen;
        replyBuf <= pollMasked;
      end else if (strobes.ackBus) begin
        replyLen <= '0;
        replyBuf <= '0;
      end
      rspValid <= strobes.ackBus || strobes.ackAll;
      if (strobes.ackBus) begin
        rspLen  <= LEN_W'(replyLen + 1'b1);
        rspData <= {replyBuf, status & BUSGRP_M};
      end else if (strobes.ackAll) begin
        rspLen  <= LEN_W'(1);
        rspData <= {{(RSP_W-8){1'b0}}, status};
      end else begin
        rspLen  <= '0;
        rspData <= '0;
      end
    end
  end

  assign busPending = status[BUS_BIT];
  assign irqReq     = |(status & maskReg);

endmodule

// File: rtl/intr_status_latch.sv
module intr_status_latch
  import intr_latch_pkg::*;
#(
  parameter int MAX_REPLY   = 8,
  parameter int TICK_CYCLES = 100_000_000,
  parameter int TICK_BIT    = 3,
  parameter int AUTO_BIT    = 2,
  parameter int BUS_BIT     = 4,
  localparam int LEN_W      = $clog2(MAX_REPLY + 2),
  localparam int RSP_W      = (MAX_REPLY + 1) * 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   maskWrEn,
  input  logic [7:0]             maskWrData,
  input  logic                   pollValid,
  input  logic [LEN_W-1:0]       pollLen,
  input  logic [MAX_REPLY*8-1:0] pollData,
  input  logic                   ackReq,
  input  logic [7:0]             ackArgCnt,
  output logic                   irqN,
  output logic                   rspValid,
  output logic [LEN_W-1:0]       rspLen,
  output logic [RSP_W-1:0]       rspData
);

  ctrlStrobes_t strobes;
  logic         busPending;
  logic         irqReq;

  intr_latch_ctrl #(
    .TICK_CYCLES(TICK_CYCLES),
    .LEN_W      (LEN_W)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .maskWrEn  (maskWrEn),
    .pollValid (pollValid),
    .pollLen   (pollLen),
    .ackReq    (ackReq),
    .ackArgCnt (ackArgCnt),
    .busPending(busPending),
    .strobes   (strobes)
  );

  intr_latch_dp #(
    .MAX_REPLY(MAX_REPLY),
    .TICK_BIT (TICK_BIT),
    .AUTO_BIT (AUTO_BIT),
    .BUS_BIT  (BUS_BIT),
    .LEN_W    (LEN_W),
    .RSP_W    (RSP_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .maskWrData(maskWrData),
    .pollLen   (pollLen),
    .pollData  (pollData),
    .busPending(busPending),
    .irqReq    (irqReq),
    .rspValid  (rspValid),
    .rspLen    (rspLen),
    .rspData   (rspData)
  );

  assign irqN = ~irqReq;

endmodule

// File: rtl/intr_latch_chk.sv
module intr_latch_chk
  import intr_latch_pkg::*;
#(
  parameter int TICK_CYCLES = 100_000_000,
  parameter int AUTO_BIT    = 2,
  parameter int BUS_BIT     = 4,
  parameter int LEN_W       = 4,
  parameter int RSP_W       = 72
) (
  input logic             clk,
  input logic             rstN,
  input logic             ackReq,
  input logic [7:0]       ackArgCnt,
  input logic             irqN,
  input logic             rspValid,
  input logic [LEN_W-1:0] rspLen,
  input logic [RSP_W-1:0] rspData,
  input ctrlStrobes_t     strobes
);

  localparam logic [7:0] BUSGRP_M = 8'((1 << BUS_BIT) | (1 << AUTO_BIT));

  logic [31:0] sinceTick;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               sinceTick <= '0;
    else if (strobes.tickSet) sinceTick <= '0;
    else                      sinceTick <= sinceTick + 1'b1;
  end

  p_reset_quiet_r2: assert property (@(posedge clk)
    !rstN |=> (irqN && !rspValid));

  p_irq_cause_r1: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irqN) |-> $past(strobes.tickSet || strobes.pollCap || strobes.maskWr));

  p_tick_period_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.tickSet |-> (sinceTick == 32'(TICK_CYCLES - 1)));

  p_rsp_cause_r5: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(ackReq && (ackArgCnt == 8'd0)));

  p_bus_header_r5: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && (rspLen > LEN_W'(1))) |->
      (rspData[BUS_BIT] && ((rspData[7:0] & ~BUSGRP_M) == 8'h00)));

  p_single_byte_r6: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && (rspLen == LEN_W'(1))) |-> (rspData[RSP_W-1:8] == '0));

  p_ack_args_ignored_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ackReq && (ackArgCnt != 8'd0)) |=> !rspValid);

endmodule

bind intr_status_latch intr_latch_chk #(
  .TICK_CYCLES(TICK_CYCLES),
  .AUTO_BIT   (AUTO_BIT),
  .BUS_BIT    (BUS_BIT),
  .LEN_W      (LEN_W),
  .RSP_W      (RSP_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .ackReq   (ackReq),
  .ackArgCnt(ackArgCnt),
  .irqN     (irqN),
  .rspValid (rspValid),
  .rspLen   (rspLen),
  .rspData  (rspData),
  .strobes  (strobes)
);

// File: tb/test_intr_status_latch.sv
module test_intr_status_latch;

  localparam int PERIOD = 10;
  localparam int TICKS  = 200;
  localparam int NV     = 18;

  localparam logic [1:0] OP_MASK = 2'd0;
  localparam logic [1:0] OP_POLL = 2'd1;
  localparam logic [1:0] OP_ACK  = 2'd2;

  typedef struct packed {
    logic [1:0]  op;
    logic [7:0]  cnt;
    logic [3:0]  plen;
    logic [63:0] pdata;
    logic [7:0]  mval;
    logic        ev;
    logic [3:0]  elen;
    logic [71:0] edata;
    logic        eirqN;
    logic [3:0]  req;
  } vec_t;

  function automatic vec_t mk(logic [1:0] op, logic [7:0] cnt, logic [3:0] plen,
                              logic [63:0] pdata, logic [7:0] mval, logic ev,
                              logic [3:0] elen, logic [71:0] edata, logic eirqN,
                              logic [3:0] req);
    vec_t v;
    v.op = op; v.cnt = cnt; v.plen = plen; v.pdata = pdata; v.mval = mval;
    v.ev = ev; v.elen = elen; v.edata = edata; v.eirqN = eirqN; v.req = req;
    return v;
  endfunction

  localparam vec_t VECS [NV] = '{
    mk(OP_ACK,  8'd0,   4'd0, 64'h0,                 8'h00, 1'b1, 4'd1, 72'h00,         1'b1, 4'd6), // R6 empty
    mk(OP_POLL, 8'd0,   4'd3, 64'hDDAABBCC,          8'h00, 1'b0, 4'd0, 72'h0,          1'b0, 4'd4), // R4 capture
    mk(OP_POLL, 8'd0,   4'd2, 64'h1122,              8'h00, 1'b0, 4'd0, 72'h0,          1'b0, 4'd4), // R4 held
    mk(OP_ACK,  8'd2,   4'd0, 64'h0,                 8'h00, 1'b0, 4'd0, 72'h0,          1'b0, 4'd7), // R7
    mk(OP_ACK,  8'd0,   4'd0, 64'h0,                 8'h00, 1'b1, 4'd4, 72'hAABBCC14,   1'b1, 4'd5), // R5
    mk(OP_ACK,  8'd0,   4'd0, 64'h0,                 8'h00, 1'b1, 4'd1, 72'h00,         1'b1, 4'd5), // R5 cleared
    mk(OP_POLL, 8'd0,   4'd0, 64'h55,                8'h00, 1'b0, 4'd0, 72'h0,          1'b1, 4'd4), // R4 zero len
    mk(OP_ACK,  8'd0,   4'd0, 64'h0,                 8'h00, 1'b1, 4'd1, 72'h00,         1'b1, 4'd4), // R4
    mk(OP_MASK, 8'd0,   4'd0, 64'h0,                 8'h00, 1'b0, 4'd0, 72'h0,          1'b1, 4'd9), // R9
    mk(OP_POLL, 8'd0,   4'd1, 64'h77,                8'h00, 1'b0, 4'd0, 72'h0,          1'b1, 4'd1), // R1 masked
    mk(OP_MASK, 8'd0,   4'd0, 64'h0,                 8'h04, 1'b0, 4'd0, 72'h0,          1'b0, 4'd1), // R1 mask change
    mk(OP_MASK, 8'd0,   4'd0, 64'h0,                 8'h08, 1'b0, 4'd0, 72'h0,          1'b1, 4'd9), // R9
    mk(OP_ACK,  8'd0,   4'd0, 64'h0,                 8'h00, 1'b1, 4'd2, 72'h7714,       1'b1, 4'd5), // R5
    mk(OP_MASK, 8'd0,   4'd0, 64'h0,                 8'h18, 1'b0, 4'd0, 72'h0,          1'b1, 4'd9), // R9
    mk(OP_POLL, 8'd0,   4'd8, 64'h0102030405060708,  8'h00, 1'b0, 4'd0, 72'h0,          1'b0, 4'd4), // R4 full
    mk(OP_ACK,  8'hFF,  4'd0, 64'h0,                 8'h00, 1'b0, 4'd0, 72'h0,          1'b0, 4'd7), // R7
    mk(OP_ACK,  8'd0,   4'd0, 64'h0,                 8'h00, 1'b1, 4'd9, 72'h0102030405060708_14, 1'b1, 4'd5), // R5
    mk(OP_ACK,  8'd0,   4'd0, 64'h0,                 8'h00, 1'b1, 4'd1, 72'h00,         1'b1, 4'd6)  // R6
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        maskWrEn = 1'b0;
  logic [7:0]  maskWrData = 8'h00;
  logic        pollValid = 1'b0;
  logic [3:0]  pollLen = 4'd0;
  logic [63:0] pollData = 64'h0;
  logic        ackReq = 1'b0;
  logic [7:0]  ackArgCnt = 8'd0;
  logic        irqN;
  logic        rspValid;
  logic [3:0]  rspLen;
  logic [71:0] rspData;

  int nChecks = 0;
  int nFails  = 0;
  int ec      = 0;

  intr_status_latch #(
    .MAX_REPLY  (8),
    .TICK_CYCLES(TICKS)
  ) i_intr_status_latch (
    .clk       (clk),
    .rstN      (rstN),
    .maskWrEn  (maskWrEn),
    .maskWrData(maskWrData),
    .pollValid (pollValid),
    .pollLen   (pollLen),
    .pollData  (pollData),
    .ackReq    (ackReq),
    .ackArgCnt (ackArgCnt),
    .irqN      (irqN),
    .rspValid  (rspValid),
    .rspLen    (rspLen),
    .rspData   (rspData)
  );

  always #(PERIOD/2) clk = ~clk;

  always @(posedge clk) ec <= rstN ? ec + 1 : 0;

  task automatic chk(string tag, logic [71:0] act, logic [71:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h (edge %0d)", tag, act, exp, ec);
    end
  endtask

  task automatic idleInputs();
    maskWrEn = 1'b0; pollValid = 1'b0; ackReq = 1'b0;
    ackArgCnt = 8'd0; pollLen = 4'd0; pollData = 64'h0; maskWrData = 8'h00;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    idleInputs();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic atEc(int n);
    while (ec < n) @(negedge clk);
  endtask

  initial begin
    #(PERIOD * 20000);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    // R2: reset state at the ports
    doReset();
    chk("R2 irqN", 72'(irqN), 72'd1);
    chk("R2 rspValid", 72'(rspValid), 72'd0);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VECS[i];
      idleInputs();
      case (v.op)
        OP_MASK: begin maskWrEn = 1'b1; maskWrData = v.mval; end
        OP_POLL: begin pollValid = 1'b1; pollLen = v.plen; pollData = v.pdata; end
        default: begin ackReq = 1'b1; ackArgCnt = v.cnt; end
      endcase
      @(negedge clk);
      idleInputs();
      chk($sformatf("R%0d vec%0d rspValid", v.req, i), 72'(rspValid), 72'(v.ev));
      if (v.ev) begin
        chk($sformatf("R%0d vec%0d rspLen", v.req, i), 72'(rspLen), 72'(v.elen));
        chk($sformatf("R%0d vec%0d rspData", v.req, i), rspData, v.edata);
      end
      chk($sformatf("R1 vec%0d irqN", i), 72'(irqN), 72'(v.eirqN));
    end

    // Tick timing and collision cases
    doReset();
    atEc(TICKS - 1);
    chk("R3 before first tick", 72'(irqN), 72'd1);
    atEc(TICKS);
    chk("R3 first tick", 72'(irqN), 72'd0);

    atEc(TICKS + 2);
    pollValid = 1'b1; pollLen = 4'd1; pollData = 64'h99;
    atEc(TICKS + 3);
    idleInputs();
    ackReq = 1'b1;
    atEc(TICKS + 4);
    chk("R5 valid", 72'(rspValid), 72'd1);
    chk("R5 len", 72'(rspLen), 72'd2);
    chk("R5 data", rspData, 72'h9914);
    chk("R5 tick kept", 72'(irqN), 72'd0);
    atEc(TICKS + 5);
    idleInputs();
    chk("R6 len", 72'(rspLen), 72'd1);
    chk("R6 data", rspData, 72'h08);
    chk("R6 cleared", 72'(irqN), 72'd1);

    // R8 + R3: ack lands on the second tick edge
    atEc(2 * TICKS - 1);
    ackReq = 1'b1;
    atEc(2 * TICKS);
    chk("R8 ack rsp", rspData, 72'h00);
    chk("R8 tick survives", 72'(irqN), 72'd0);
    // R8: poll capture together with full-status clear
    pollValid = 1'b1; pollLen = 4'd1; pollData = 64'h42;
    atEc(2 * TICKS + 1);
    pollValid = 1'b0;
    chk("R6 status rsp", rspData, 72'h08);
    chk("R8 poll survives", 72'(irqN), 72'd0);
    atEc(2 * TICKS + 2);
    idleInputs();
    chk("R8 reply len", 72'(rspLen), 72'd2);
    chk("R8 reply data", rspData, 72'h4214);
    chk("R8 idle after", 72'(irqN), 72'd1);

    atEc(3 * TICKS - 1);
    chk("R3 before third tick", 72'(irqN), 72'd1);
    atEc(3 * TICKS);
    chk("R3 third tick", 72'(irqN), 72'd0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule